// File: doc/BRIEF.md
# SPI Command Register Interface

This block is a serial slave that sits beside the power-management core and turns one-byte commands into control levels. A host selects it with an active-low chip select, clocks in an opcode most significant bit first, and then either writes a 16-bit control word, reads that word back, reads an 8-bit fault snapshot supplied by the fault-detection logic, or toggles a write-permission flag. Both idle-low and idle-high clock polarity work: data is taken on rising serial clock edges and the reply changes after falling ones.

The serial pins are oversampled in the core clock domain through a synchronizer, so the serial clock must be several times slower than the core clock. The stored control word drives the enable outputs for the auxiliary regulator, the two load switches, the switcher and its frequency choice, plus the test-mode and diagnostic-start levels. A synchronous core reset turns every enable off and drops write permission.

Top module: `spi_cmd_regif`

## Requirements
- R1: While `rst` is high and after it, the control word reads 0x0000, every enable output is 0, write permission is cleared and `spi_miso_oe` is 0 when deselected.
- R2: Opcodes are 0x06 (grant write), 0x04 (revoke write), 0x02 (write control word), 0x05 (read fault snapshot), 0x03 (read control word), sent MSB first; input is sampled on rising serial clock edges in both clock polarities.
- R3: A write frame commits its word only when write permission is set; otherwise the control word is unchanged.
- R4: Opcode 0x06 sets write permission, 0x04 clears it, and every completed write clears it, so each write needs a fresh 0x06.
- R5: A write frame is 24 clocks, opcode then word bit 15 first; bit 15 drives `ldo_en`, 14 `drv1_en`, 13 `drv2_en`, 10 `fsel_high` (1 = high frequency), 9 `buck_en`, 1 `test_mode`, 0 `diag_start`.
- R6: Word bits 12, 11 and 8 down to 2 have no function and always store as 0.
- R7: When a written word has bit 1 set, bits 15 down to 2 store as 0.
- R8: A read of the control word returns 16 bits MSB first after the opcode; a read of the fault snapshot returns `diag_in` bit 7 first, captured when the opcode completes; reply bits change after falling clock edges.
- R9: After 0x06 or 0x04 the rest of the frame is ignored until chip select rises.
- R10: An unknown opcode is ignored together with the rest of its frame and leaves permission and word as they were.
- R11: A write frame cut short by chip select rising before bit 24 changes neither the word nor the permission flag.
- R12: `spi_miso_oe` is high while a frame is in progress and low within a few core cycles of chip select going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous core reset, active high |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial reply data |
| spi_miso_oe | output | 1 | Reply driver enable; 0 means high impedance |
| diag_in | input | DIAG_W | Fault snapshot from the detection logic |
| ldo_en | output | 1 | Auxiliary regulator enable |
| drv1_en | output | 1 | Load switch 1 enable |
| drv2_en | output | 1 | Load switch 2 enable |
| fsel_high | output | 1 | Switcher frequency select, 1 = high |
| buck_en | output | 1 | Switcher enable |
| test_mode | output | 1 | Test-mode level |
| diag_start | output | 1 | Diagnostic start level |

## Verification
The last rising clock edge of a write frame both commits the word and revokes write permission in one core cycle, so a word commit and the permission drop always coincide. The bench provokes this with back-to-back write frames, the second without a fresh grant, and judges it by reading the word back: the first value must survive. The same coincidence is provoked against an aborted write, where neither may happen, and the following unguarded full write must then succeed.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int STAT_W = 16;
  localparam int OP_W   = 8;

  localparam logic [OP_W-1:0] OP_GRANT  = 8'h06;
  localparam logic [OP_W-1:0] OP_REVOKE = 8'h04;
  localparam logic [OP_W-1:0] OP_WRWORD = 8'h02;
  localparam logic [OP_W-1:0] OP_RDDIAG = 8'h05;
  localparam logic [OP_W-1:0] OP_RDWORD = 8'h03;

  localparam int B_LDO  = 15;
  localparam int B_DRV1 = 14;
  localparam int B_DRV2 = 13;
  localparam int B_FSEL = 10;
  localparam int B_BUCK = 9;
  localparam int B_TEST = 1;
  localparam int B_DIAG = 0;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_CMD,
    FS_WDATA,
    FS_RDATA,
    FS_HOLD
  } frame_state_t;

  function automatic logic [STAT_W-1:0] bit_at(input int pos);
    logic [STAT_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [STAT_W-1:0] live_mask();
    return bit_at(B_LDO) | bit_at(B_DRV1) | bit_at(B_DRV2) | bit_at(B_FSEL)
         | bit_at(B_BUCK) | bit_at(B_TEST) | bit_at(B_DIAG);
  endfunction

  // Word as it is stored: dead bits dropped, test mode keeps only the low two.
  function automatic logic [STAT_W-1:0] clean_word(input logic [STAT_W-1:0] raw);
    logic [STAT_W-1:0] m;
    m = raw[B_TEST] ? (bit_at(B_TEST) | bit_at(B_DIAG)) : live_mask();
    return raw & m;
  endfunction

  function automatic logic is_known_op(input logic [OP_W-1:0] op);
    return (op == OP_GRANT) || (op == OP_REVOKE) || (op == OP_WRWORD)
        || (op == OP_RDDIAG) || (op == OP_RDWORD);
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic mosi_s
);
  localparam int LANES = 3;
  localparam logic [LANES-1:0] RST_LANES = 3'b010;

  logic [SYNC_STAGES-1:0][LANES-1:0] chain;
  logic [LANES-1:0] last;
  logic sclk_prev;

  assign last = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= RST_LANES;
      sclk_prev <= 1'b0;
    end else begin
      chain[0] <= {mosi, cs_n, sclk};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      sclk_prev <= last[0];
    end
  end

  assign sclk_rise = last[0] & ~sclk_prev;
  assign sclk_fall = ~last[0] & sclk_prev;
  assign cs_idle   = last[1];
  assign mosi_s    = last[2];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int DIAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_idle,
  input  logic              mosi_s,
  input  logic              wel_q,
  input  logic [STAT_W-1:0] status_q,
  input  logic [DIAG_W-1:0] diag_in,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              wr_commit,
  output logic [STAT_W-1:0] wr_data,
  output logic              miso_d,
  output logic              miso_oe
);
  localparam int CNT_W = $clog2(STAT_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(STAT_W - 1);
  localparam int PAD_W = STAT_W - DIAG_W;

  frame_state_t state;
  logic [CNT_W-1:0]  cnt;
  logic [STAT_W-1:0] rx_sh;
  logic [STAT_W-1:0] tx_sh;
  logic [STAT_W-1:0] rx_next;
  logic [OP_W-1:0]   cmd_byte;
  logic              cmd_done;
  logic              word_done;

  assign rx_next   = {rx_sh[STAT_W-2:0], mosi_s};
  assign cmd_byte  = rx_next[OP_W-1:0];
  assign cmd_done  = (state == FS_CMD) && sclk_rise && (cnt == CMD_LAST);
  assign word_done = (state == FS_WDATA) && sclk_rise && (cnt == WORD_LAST);

  assign wel_set   = cmd_done && (cmd_byte == OP_GRANT);
  assign wel_clr   = cmd_done && (cmd_byte == OP_REVOKE);
  assign wr_commit = word_done && wel_q;
  assign wr_data   = rx_next;
  assign miso_oe   = (state != FS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FS_IDLE;
      cnt    <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      miso_d <= 1'b0;
    end else if (cs_idle) begin
      state  <= FS_IDLE;
      cnt    <= '0;
      miso_d <= 1'b0;
    end else begin
      unique case (state)
        FS_IDLE: begin
          state <= FS_CMD;
          cnt   <= '0;
        end
        FS_CMD: begin
          if (sclk_rise) begin
            rx_sh <= rx_next;
            cnt   <= cnt + 1'b1;
            if (cnt == CMD_LAST) begin
              cnt <= '0;
              if (!is_known_op(cmd_byte)) begin
                state <= FS_HOLD;
              end else if (cmd_byte == OP_WRWORD) begin
                state <= FS_WDATA;
              end else if (cmd_byte == OP_RDWORD) begin
                tx_sh <= status_q;
                state <= FS_RDATA;
              end else if (cmd_byte == OP_RDDIAG) begin
                tx_sh <= {diag_in, {PAD_W{1'b0}}};
                state <= FS_RDATA;
              end else begin
                state <= FS_HOLD;
              end
            end
          end
        end
        FS_WDATA: begin
          if (sclk_rise) begin
            rx_sh <= rx_next;
            cnt   <= cnt + 1'b1;
            if (cnt == WORD_LAST) state <= FS_HOLD;
          end
        end
        FS_RDATA: begin
          if (sclk_fall) begin
            miso_d <= tx_sh[STAT_W-1];
            tx_sh  <= {tx_sh[STAT_W-2:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              wr_commit,
  input  logic [STAT_W-1:0] wr_data,
  output logic              wel_q,
  output logic [STAT_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q    <= 1'b0;
      status_q <= '0;
    end else begin
      if (wr_commit) begin
        status_q <= clean_word(wr_data);
        wel_q    <= 1'b0;
      end else if (wel_set) begin
        wel_q <= 1'b1;
      end else if (wel_clr) begin
        wel_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regif.sv
module spi_cmd_regif
  import spi_cmd_pkg::*;
#(
  parameter int DIAG_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [DIAG_W-1:0] diag_in,
  output logic              ldo_en,
  output logic              drv1_en,
  output logic              drv2_en,
  output logic              fsel_high,
  output logic              buck_en,
  output logic              test_mode,
  output logic              diag_start
);
  logic sclk_rise, sclk_fall, cs_idle, mosi_s;
  logic wel_set, wel_clr, wr_commit, wel_q;
  logic [STAT_W-1:0] wr_data;
  logic [STAT_W-1:0] status_q;

  spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_idle(cs_idle), .mosi_s(mosi_s)
  );

  spi_frame_ctrl #(.DIAG_W(DIAG_W)) u_frame (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .mosi_s(mosi_s), .wel_q(wel_q), .status_q(status_q),
    .diag_in(diag_in), .wel_set(wel_set), .wel_clr(wel_clr), .wr_commit(wr_commit),
    .wr_data(wr_data), .miso_d(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_status_reg u_reg (
    .clk(clk), .rst(rst), .wel_set(wel_set), .wel_clr(wel_clr),
    .wr_commit(wr_commit), .wr_data(wr_data), .wel_q(wel_q), .status_q(status_q)
  );

  assign ldo_en     = status_q[B_LDO];
  assign drv1_en    = status_q[B_DRV1];
  assign drv2_en    = status_q[B_DRV2];
  assign fsel_high  = status_q[B_FSEL];
  assign buck_en    = status_q[B_BUCK];
  assign test_mode  = status_q[B_TEST];
  assign diag_start = status_q[B_DIAG];

endmodule

// File: rtl/spi_cmd_regif_chk.sv
module spi_cmd_regif_chk
  import spi_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_commit,
  input logic              wel_set,
  input logic              wel_clr,
  input logic              wel_q,
  input logic [STAT_W-1:0] status_q,
  input logic              cs_idle,
  input logic              spi_miso_oe
);
  localparam logic [STAT_W-1:0] DEAD = ~live_mask();

  AST_COMMIT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> wel_q); // R3
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_commit |=> $stable(status_q)); // R3
  AST_LATCH_DROPS_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wel_q); // R4
  AST_LATCH_SET_BY_GRANT: assert property (@(posedge clk) disable iff (rst)
    wel_set |=> wel_q); // R4
  AST_LATCH_CLR_BY_REVOKE: assert property (@(posedge clk) disable iff (rst)
    wel_clr |=> !wel_q); // R4
  AST_LATCH_RISE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_q) |-> $past(wel_set)); // R4
  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status_q & DEAD) == '0); // R6
  AST_TEST_MASK: assert property (@(posedge clk) disable iff (rst)
    status_q[B_TEST] |-> (status_q[STAT_W-1:2] == '0)); // R7
  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !spi_miso_oe); // R12

endmodule

bind spi_cmd_regif spi_cmd_regif_chk u_chk (
  .clk(clk), .rst(rst), .wr_commit(wr_commit), .wel_set(wel_set), .wel_clr(wel_clr),
  .wel_q(wel_q), .status_q(status_q), .cs_idle(cs_idle), .spi_miso_oe(spi_miso_oe)
);

// File: tb/spi_cmd_regif_test.sv
module spi_cmd_regif_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic [7:0] diag = 8'h00;
  logic ldo, d1, d2, fs, bk, tm, ds;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  string       exp_req_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];

  always #4 clk = ~clk;

  spi_cmd_regif uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .diag_in(diag),
    .ldo_en(ldo), .drv1_en(d1), .drv2_en(d2), .fsel_high(fs), .buck_en(bk),
    .test_mode(tm), .diag_start(ds)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Stored form of a word, stated from the bit rules.
  function automatic logic [15:0] stored(input logic [15:0] w);
    if (w[1]) return {14'b0, w[1:0]};
    return {w[15:13], 2'b00, w[10:9], 7'b0, w[1:0]};
  endfunction

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input bit cpol, input int nbits, input logic [23:0] d,
                      input bit oe_chk, output logic [23:0] q);
    q = '0;
    sclk = cpol;
    half_wait();
    cs_n = 1'b0;
    half_wait();
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = d[23-i];
      half_wait();
      q = {q[22:0], miso};
      if (oe_chk && i == 4) chk("R12 oe during frame", miso_oe, 1);
      sclk = 1'b1;
      half_wait();
    end
    if (!cpol) begin
      sclk = 1'b0;
      half_wait();
    end
    cs_n = 1'b1;
    half_wait();
    half_wait();
  endtask

  task automatic op(input bit cpol, input logic [7:0] code);
    logic [23:0] q;
    xfer(cpol, 8, {code, 16'h0}, 1'b0, q);
  endtask

  task automatic wr(input bit cpol, input logic [15:0] w);
    logic [23:0] q;
    xfer(cpol, 24, {8'h02, w}, 1'b0, q);
  endtask

  task automatic rd_word(input bit cpol, input string req, input logic [15:0] exp);
    logic [23:0] q;
    exp_req_q.push_back(req);
    exp_q.push_back(exp);
    xfer(cpol, 24, {8'h03, 16'h0}, 1'b1, q);
    act_q.push_back(q[15:0]);
  endtask

  task automatic rd_diag(input bit cpol, input string req, input logic [7:0] exp);
    logic [23:0] q;
    exp_req_q.push_back(req);
    exp_q.push_back({8'h00, exp});
    xfer(cpol, 16, {8'h05, 16'h0}, 1'b0, q);
    act_q.push_back({8'h00, q[7:0]});
  endtask

  task automatic chk_outs(input string req, input logic [15:0] w);
    chk(req, {ldo, d1, d2, fs, bk, tm, ds},
        {w[15], w[14], w[13], w[10], w[9], w[1], w[0]});
  endtask

  // Scoreboard monitor: pairs each finished read with its expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        chk(exp_req_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] q;
    repeat (6) @(negedge clk);
    chk_outs("R1 outputs in reset", 16'h0000);
    chk("R1 oe in reset", miso_oe, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    rd_word(0, "R1 word after reset", 16'h0000);

    // R3: write with no grant
    wr(0, 16'hE603);
    rd_word(0, "R3 unguarded write ignored", 16'h0000);

    // R5 / R2: granted write, mode 0
    op(0, 8'h06);
    wr(0, 16'hA401);
    chk_outs("R5 enable mapping", 16'hA401);
    rd_word(0, "R5 word readback", stored(16'hA401));

    // R4: permission consumed by the write
    wr(0, 16'h0200);
    rd_word(0, "R4 second write needs new grant", 16'hA401);

    // R6 / R2: dead bits, clock polarity high
    op(1, 8'h06);
    wr(1, 16'hFFFD);
    rd_word(1, "R6 dead bits store zero", stored(16'hFFFD));

    // R4: revoke
    op(0, 8'h06);
    op(0, 8'h04);
    wr(0, 16'h0000);
    rd_word(0, "R4 revoke blocks write", 16'hE601);

    // R9: grant frame with trailing write bits
    xfer(0, 24, {8'h06, 8'h02, 8'h00}, 1'b0, q);
    rd_word(0, "R9 trailing bits ignored", 16'hE601);
    wr(0, 16'h4200);
    rd_word(0, "R9 grant still executed", 16'h4200);

    // R10: unknown opcode keeps state and permission
    op(0, 8'h06);
    xfer(0, 24, {8'h07, 16'h8000}, 1'b0, q);
    rd_word(0, "R10 unknown opcode ignored", 16'h4200);
    wr(0, 16'h8000);
    rd_word(0, "R10 permission kept", 16'h8000);

    // R11: aborted write
    op(0, 8'h06);
    xfer(0, 16, {8'h02, 8'hA4, 8'h00}, 1'b0, q);
    rd_word(0, "R11 aborted write no change", 16'h8000);
    wr(0, 16'h2400);
    rd_word(0, "R11 permission survives abort", 16'h2400);

    // R7: test mode
    op(0, 8'h06);
    wr(0, 16'hFFFF);
    chk_outs("R7 test mode outputs", 16'h0003);
    rd_word(0, "R7 test mode word", stored(16'hFFFF));

    // R8: fault snapshot in both polarities
    diag = 8'hA5;
    rd_diag(0, "R8 diag read mode 0", 8'hA5);
    diag = 8'h3C;
    rd_diag(1, "R8 diag read clock idle high", 8'h3C);

    // R12: deselected
    chk("R12 oe after deselect", miso_oe, 0);

    // R1: core reset mid-operation
    op(0, 8'h06);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs("R1 outputs after core reset", 16'h0000);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    rd_word(0, "R1 word after core reset", 16'h0000);
    wr(0, 16'hFFFF);
    rd_word(0, "R1 permission cleared by reset", 16'h0000);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule